// File: doc/BRIEF.md
# Frame-Synced Serial Codec Port

This block is the serial port that connects a codec to a host signal processor. It makes its own serial clock by dividing the master clock, and it exchanges 16-bit words in both directions, most significant bit first. On the transmit side the host hands over a parallel word through a ready/valid handshake. The port then raises a one-period frame pulse and shifts the word out. On the receive side the port watches an incoming frame pulse, deserialises the word that follows, and presents it on a parallel bus with a one-cycle valid strobe.

The two directions use opposite serial clock edges. Outgoing bits and the outgoing frame pulse change on the rising edge. Incoming bits and the incoming frame pulse are sampled on the falling edge, so a port can loop back onto itself. The enable input is synchronised into the master clock domain. While it is low, the port goes silent: the serial clock stops, the drivers are released and the inputs are ignored. The word buffer and the divider settings survive a disabled interval. All timing state restarts from scratch when the port is enabled again.

Top module: `fsp_port`

## Requirements
- R1: One serial clock period lasts Ep*Er master clock cycles, where Ep and Er are the prescale and rate settings with 0 and 1 both meaning 1. A product below 2 is raised to 2. The clock is high for the first ceil(P/2) cycles of each period P and low for the rest.
- R2: `sdo` changes only in the master cycle in which `sclk` rises. The 16 bits of a word go out most significant bit first.
- R3: `txFs` is high for exactly one serial period, and the first data bit follows in the next period. `sdoOe` is high for exactly the 16 data periods of a word and low otherwise, including while `txFs` is high.
- R4: A high `rxFs` sampled at a falling `sclk` edge starts a word. The next 16 falling edges sample `sdi`, most significant bit first. After the last sample, `rxData` holds the word and `rxValid` is high for one master cycle.
- R5: `txReady` is high when the port is enabled and its one-word buffer is empty. A word is taken when `txValid` and `txReady` are both high at a clock edge, and `txReady` is low in the following cycle.
- R6: While `portEn` is low (after a two-cycle synchroniser): `sclk` stays low, `sdoOe` and `txFsOe` are low, `txReady` is low, and `rxFs` and `sdi` have no effect on `rxValid` or `rxData`.
- R7: A disabled interval keeps `rxData`, the buffered transmit word and the active divider settings. The divider counter, the bit counters and any frame in progress restart from idle.
- R8: An active-low `rstN` clears every register: the outputs read `sclk`=0, `sdoOe`=0, `txFsOe`=0, `txReady`=0, `rxValid`=0 and `rxData`=0.
- R9: New `cfgPre`/`cfgRate` values are adopted only at a rising `sclk` edge at which neither direction is inside a word. Periods within a word keep the old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| portEn | input | 1 | Asynchronous port enable |
| cfgPre | input | DIV_W | Master clock prescale setting |
| cfgRate | input | DIV_W | Serial clock rate setting |
| txData | input | WORD_W | Parallel word to send |
| txValid | input | 1 | Host offers `txData` |
| txReady | output | 1 | Port can take a word |
| sclk | output | 1 | Generated serial clock |
| sdo | output | 1 | Serial data out |
| sdoOe | output | 1 | Drive enable for `sdo` |
| txFs | output | 1 | Outgoing frame pulse |
| txFsOe | output | 1 | Drive enable for `txFs` |
| sdi | input | 1 | Serial data in |
| rxFs | input | 1 | Incoming frame pulse |
| rxData | output | WORD_W | Last received word |
| rxValid | output | 1 | One-cycle strobe for a new `rxData` |

## Verification
Two events can land in the same master cycle: the handshake that refills the transmit buffer, and a receive completion or a divider change. The bench wires the port back onto itself and queues words back to back, so buffer refills fall inside frames that are still being sent and received. A divider change is applied in the middle of a word. The bench then judges both the decoded words and the measured serial period before and after the boundary. A disable is also applied in the middle of a frame while a second word waits in the buffer. The scoreboard expects the interrupted word to disappear and the buffered word to come out intact.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

  typedef struct packed {
    logic run;        // enable synchronised high
    logic rise;       // serial clock rises at this edge
    logic fall;       // serial clock falls at this edge
    logic txAccept;   // host word taken into buffer
    logic txLoad;     // buffer moved into shifter
    logic txShift;    // shifter advances one bit
    logic rxCapture;  // sample one input bit
    logic rxDone;     // last input bit sampled
  } fspStrobes_t;

  typedef enum logic [1:0] {TX_IDLE, TX_FS, TX_DATA} fspTxState_t;
  typedef enum logic {RX_IDLE, RX_DATA} fspRxState_t;

endpackage

// File: rtl/fsp_ctrl.sv
module fsp_ctrl
  import fsp_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DIV_W  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             portEn,
  input  logic [DIV_W-1:0] cfgPre,
  input  logic [DIV_W-1:0] cfgRate,
  input  logic             txValid,
  input  logic             rxFs,
  output fspStrobes_t      stb,
  output logic             txReady,
  output logic             sclk,
  output logic             txFs,
  output logic             txFsOe,
  output logic             sdoOe
);
  localparam int PROD_W = 2 * DIV_W;
  localparam int BIT_W  = $clog2(WORD_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  logic [1:0]        enSync;
  logic [DIV_W-1:0]  preAct, rateAct;
  logic [PROD_W-1:0] effDiv [2];
  logic [PROD_W-1:0] prod, nDiv, hiLen, divCnt;
  logic              txHave, sclkQ, txFsQ, sdoOeQ;
  logic [BIT_W-1:0]  txBit, rxBit;
  fspTxState_t       txSt;
  fspRxState_t       rxSt;
  logic              run, boundary;

  // settings of 0 or 1 both mean divide-by-one
  for (genvar g = 0; g < 2; g++) begin : g_eff
    logic [DIV_W-1:0] raw;
    assign raw       = (g == 0) ? preAct : rateAct;
    assign effDiv[g] = (raw < DIV_W'(2)) ? PROD_W'(1) : PROD_W'(raw);
  end

  assign prod     = effDiv[0] * effDiv[1];
  assign nDiv     = (prod < PROD_W'(2)) ? PROD_W'(2) : prod;
  assign hiLen    = nDiv - (nDiv >> 1);
  assign run      = enSync[1];
  assign boundary = (txSt == TX_IDLE) && (rxSt == RX_IDLE);

  always_comb begin
    stb           = '0;
    stb.run       = run;
    stb.rise      = run && (divCnt == nDiv - PROD_W'(1));
    stb.fall      = run && (divCnt == hiLen - PROD_W'(1));
    stb.txAccept  = txValid && txReady;
    stb.txLoad    = stb.rise && (txSt == TX_IDLE) && txHave;
    stb.txShift   = stb.rise && (txSt == TX_DATA) && (txBit != LAST_BIT);
    stb.rxCapture = stb.fall && (rxSt == RX_DATA);
    stb.rxDone    = stb.rxCapture && (rxBit == LAST_BIT);
  end

  assign txReady = run && !txHave;
  assign sclk    = sclkQ;
  assign txFs    = txFsQ;
  assign txFsOe  = run;
  assign sdoOe   = sdoOeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enSync <= '0;
    else       enSync <= {enSync[0], portEn};
  end

  // configuration and buffer state: kept across a disabled interval
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preAct  <= '0;
      rateAct <= '0;
      txHave  <= 1'b0;
    end else begin
      if (stb.txLoad)        txHave <= 1'b0;
      else if (stb.txAccept) txHave <= 1'b1;
      if (stb.rise && boundary) begin
        preAct  <= cfgPre;
        rateAct <= cfgRate;
      end
    end
  end

  // timing state: cleared by reset and by a low enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0; sclkQ <= 1'b0; txFsQ <= 1'b0; sdoOeQ <= 1'b0;
      txSt <= TX_IDLE; txBit <= '0; rxSt <= RX_IDLE; rxBit <= '0;
    end else if (!run) begin
      divCnt <= '0; sclkQ <= 1'b0; txFsQ <= 1'b0; sdoOeQ <= 1'b0;
      txSt <= TX_IDLE; txBit <= '0; rxSt <= RX_IDLE; rxBit <= '0;
    end else begin
      divCnt <= stb.rise ? '0 : divCnt + PROD_W'(1);
      if (stb.rise)      sclkQ <= 1'b1;
      else if (stb.fall) sclkQ <= 1'b0;

      unique case (txSt)
        TX_IDLE: if (stb.txLoad) begin
          txSt  <= TX_FS;
          txFsQ <= 1'b1;
        end
        TX_FS: if (stb.rise) begin
          txSt   <= TX_DATA;
          txFsQ  <= 1'b0;
          sdoOeQ <= 1'b1;
          txBit  <= '0;
        end
        TX_DATA: if (stb.rise) begin
          if (txBit == LAST_BIT) begin
            txSt   <= TX_IDLE;
            sdoOeQ <= 1'b0;
          end else begin
            txBit <= txBit + BIT_W'(1);
          end
        end
        default: txSt <= TX_IDLE;
      endcase

      unique case (rxSt)
        RX_IDLE: if (stb.fall && rxFs) begin
          rxSt  <= RX_DATA;
          rxBit <= '0;
        end
        RX_DATA: if (stb.rxCapture) begin
          if (stb.rxDone) rxSt <= RX_IDLE;
          else            rxBit <= rxBit + BIT_W'(1);
        end
        default: rxSt <= RX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fsp_datapath.sv
module fsp_datapath
  import fsp_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  fspStrobes_t       stb,
  input  logic [WORD_W-1:0] txData,
  input  logic              sdi,
  output logic              sdo,
  output logic [WORD_W-1:0] rxData,
  output logic              rxValid
);
  logic [WORD_W-1:0] txBuf, txSh, rxSh, rxNext;

  assign rxNext = {rxSh[WORD_W-2:0], sdi};
  assign sdo    = txSh[WORD_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBuf   <= '0;
      txSh    <= '0;
      rxSh    <= '0;
      rxData  <= '0;
      rxValid <= 1'b0;
    end else begin
      if (stb.txAccept) txBuf <= txData;
      if (stb.txLoad)       txSh <= txBuf;
      else if (stb.txShift) txSh <= {txSh[WORD_W-2:0], 1'b0};
      if (stb.rxCapture) rxSh <= rxNext;
      if (stb.rxDone)    rxData <= rxNext;
      rxValid <= stb.rxDone;
    end
  end

endmodule

// File: rtl/fsp_port.sv
module fsp_port
  import fsp_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DIV_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              portEn,
  input  logic [DIV_W-1:0]  cfgPre,
  input  logic [DIV_W-1:0]  cfgRate,
  input  logic [WORD_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady,
  output logic              sclk,
  output logic              sdo,
  output logic              sdoOe,
  output logic              txFs,
  output logic              txFsOe,
  input  logic              sdi,
  input  logic              rxFs,
  output logic [WORD_W-1:0] rxData,
  output logic              rxValid
);
  fspStrobes_t stb;

  fsp_ctrl #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .portEn(portEn), .cfgPre(cfgPre), .cfgRate(cfgRate),
    .txValid(txValid), .rxFs(rxFs), .stb(stb), .txReady(txReady), .sclk(sclk),
    .txFs(txFs), .txFsOe(txFsOe), .sdoOe(sdoOe)
  );

  fsp_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .txData(txData), .sdi(sdi),
    .sdo(sdo), .rxData(rxData), .rxValid(rxValid)
  );

endmodule

// File: rtl/fsp_port_chk.sv
module fsp_port_chk (
  input logic clk,
  input logic rstN,
  input logic portEn,
  input logic sclk,
  input logic sdo,
  input logic sdoOe,
  input logic txFs,
  input logic txFsOe,
  input logic txValid,
  input logic txReady,
  input logic rxValid
);
  a_r2_sdo_moves_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdo) |-> $rose(sclk));

  a_r3_oe_starts_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdoOe) |-> $rose(sclk));

  a_r3_fs_not_with_data: assert property (@(posedge clk) disable iff (!rstN)
    !(txFs && sdoOe));

  a_r4_valid_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  a_r5_accept_drops_ready: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> !txReady);

  a_r6_quiet_when_off: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(portEn, 1) && !$past(portEn, 2) && !$past(portEn, 3))
      |-> (!sclk && !sdoOe && !txFsOe && !txReady));
endmodule

bind fsp_port fsp_port_chk u_chk (
  .clk(clk), .rstN(rstN), .portEn(portEn), .sclk(sclk), .sdo(sdo),
  .sdoOe(sdoOe), .txFs(txFs), .txFsOe(txFsOe), .txValid(txValid),
  .txReady(txReady), .rxValid(rxValid)
);

// File: tb/fsp_port_tb.sv
module fsp_port_tb;
  logic clk = 1'b0, rstN = 1'b0, portEn = 1'b0;
  logic [3:0] cfgPre = '0, cfgRate = '0;
  logic [15:0] txData = '0;
  logic txValid = 1'b0, sdiDrv = 1'b0, rxFsDrv = 1'b0, loopOn = 1'b1;
  logic txReady, sclk, sdo, sdoOe, txFs, txFsOe, rxValid, sdi, rxFs;
  logic [15:0] rxData;

  assign sdi  = loopOn ? (sdo & sdoOe) : sdiDrv;
  assign rxFs = loopOn ? (txFs & txFsOe) : rxFsDrv;

  fsp_port u_dut (
    .clk(clk), .rstN(rstN), .portEn(portEn), .cfgPre(cfgPre), .cfgRate(cfgRate),
    .txData(txData), .txValid(txValid), .txReady(txReady), .sclk(sclk), .sdo(sdo),
    .sdoOe(sdoOe), .txFs(txFs), .txFsOe(txFsOe), .sdi(sdi), .rxFs(rxFs),
    .rxData(rxData), .rxValid(rxValid)
  );

  always #5 clk = ~clk;

  int nChk = 0, nBad = 0;
  logic [15:0] txQ[$], rxQ[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  // serial period measurement (R1, R9)
  time tRise = 0;
  int lastPer = 0, lastHi = 0;
  always @(posedge sclk) begin
    lastPer = int'(($time - tRise) / 10);
    tRise = $time;
  end
  always @(negedge sclk) lastHi = int'(($time - tRise) / 10);

  // transmit monitor: decodes frames at falling sclk (R2, R3)
  int monSt = 0, monN = 0;
  logic [15:0] monWord = '0;
  always @(negedge sclk) begin
    if (monSt != 0 && !sdoOe) begin
      if (txQ.size() > 0) void'(txQ.pop_front());   // frame cut short by disable
      if (rxQ.size() > 0) void'(rxQ.pop_front());
      monSt = 0;
    end
    if (monSt == 0) begin
      if (txFs && txFsOe) begin monSt = 1; monN = 0; end
    end else begin
      check(txFs == 1'b0, "R3", "txFs during data", int'(txFs), 0);
      monWord = {monWord[14:0], sdo};
      monN++;
      if (monN == 16) begin
        monSt = 0;
        if (txQ.size() == 0) check(1'b0, "R2", "unexpected tx word", int'(monWord), 0);
        else begin
          logic [15:0] e;
          e = txQ.pop_front();
          check(monWord == e, "R2", "tx word", int'(monWord), int'(e));
        end
      end
    end
  end

  // receive monitor (R4)
  always @(negedge clk) if (rxValid) begin
    if (rxQ.size() == 0) check(1'b0, "R4", "unexpected rx word", int'(rxData), 0);
    else begin
      logic [15:0] e;
      e = rxQ.pop_front();
      check(rxData == e, "R4", "rx word", int'(rxData), int'(e));
    end
  end

  task automatic sendWord(input logic [15:0] w);
    @(negedge clk);
    while (!txReady) @(negedge clk);
    txData = w; txValid = 1'b1;
    txQ.push_back(w);
    if (loopOn) rxQ.push_back(w);
    @(negedge clk);
    txValid = 1'b0;
    check(txReady == 1'b0, "R5", "ready after accept", int'(txReady), 0);
  endtask

  task automatic rxDrive(input logic [15:0] w);
    rxQ.push_back(w);
    @(posedge sclk); rxFsDrv = 1'b1;
    @(posedge sclk); rxFsDrv = 1'b0; sdiDrv = w[15];
    for (int i = 14; i >= 0; i--) begin
      @(posedge sclk); sdiDrv = w[i];
    end
    @(posedge sclk); sdiDrv = 1'b0;
  endtask

  task automatic drain();
    while (txQ.size() != 0 || rxQ.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic setDiv(input logic [3:0] p, input logic [3:0] r,
                        input int expPer, input int expHi);
    @(negedge clk); cfgPre = p; cfgRate = r;
    repeat (4) @(posedge sclk);
    @(negedge clk);
    check(lastPer == expPer, "R1", "period", lastPer, expPer);
    check(lastHi == expHi, "R1", "high time", lastHi, expHi);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog: run did not finish");
    finishRun();
  end

  initial begin
    logic [15:0] keep;
    bit sawClk, sawOe, sawVal, sawRdy;
    portEn = 1'b1;
    repeat (4) @(negedge clk);
    // R8 reset state
    check(sclk == 0 && sdoOe == 0 && txFsOe == 0, "R8", "serial outputs in reset",
          int'({sclk, sdoOe, txFsOe}), 0);
    check(rxValid == 0 && rxData == 0 && txReady == 0, "R8", "word outputs in reset",
          int'({rxValid, txReady, rxData}), 0);
    rstN = 1'b1;
    repeat (10) @(negedge clk);
    check(txReady == 1'b1, "R5", "ready when idle", int'(txReady), 1);

    setDiv(4'd0, 4'd0, 2, 1);
    setDiv(4'd1, 4'd5, 5, 3);
    setDiv(4'd3, 4'd4, 12, 6);
    setDiv(4'd2, 4'd2, 4, 2);

    // loopback words, buffer refilled while frames are in flight (R2-R5)
    sendWord(16'hA5C3);
    sendWord(16'h0001);
    sendWord(16'h8000);
    sendWord(16'hFFFF);
    drain();

    // R9: divider change in mid-word
    sendWord(16'h1234);
    while (!sdoOe) @(negedge clk);
    cfgPre = 4'd3; cfgRate = 4'd2;
    repeat (4) @(posedge sclk);
    @(negedge clk);
    check(lastPer == 4, "R9", "period kept inside word", lastPer, 4);
    drain();
    repeat (3) @(posedge sclk);
    @(negedge clk);
    check(lastPer == 6, "R9", "period after boundary", lastPer, 6);
    check(lastHi == 3, "R9", "high after boundary", lastHi, 3);

    // R4 receive driven directly
    loopOn = 1'b0;
    rxDrive(16'h6B2D);
    drain();
    check(rxData == 16'h6B2D, "R4", "direct rx word", int'(rxData), 16'h6B2D);

    // R6 disabled port ignores inputs
    portEn = 1'b0;
    repeat (4) @(negedge clk);
    keep = rxData;
    sawClk = 0; sawOe = 0; sawVal = 0; sawRdy = 0;
    for (int i = 0; i < 200; i++) begin
      rxFsDrv = (i % 7) == 0;
      sdiDrv = i[1];
      @(negedge clk);
      sawClk |= sclk; sawOe |= (sdoOe | txFsOe); sawVal |= rxValid; sawRdy |= txReady;
    end
    rxFsDrv = 1'b0; sdiDrv = 1'b0;
    check(!sawClk, "R6", "sclk while off", int'(sawClk), 0);
    check(!sawOe, "R6", "enables while off", int'(sawOe), 0);
    check(!sawVal, "R6", "rxValid while off", int'(sawVal), 0);
    check(!sawRdy, "R6", "txReady while off", int'(sawRdy), 0);
    check(rxData == keep, "R6", "rxData while off", int'(rxData), int'(keep));

    // R7 re-enable keeps data and divider
    portEn = 1'b1;
    repeat (10) @(negedge clk);
    check(rxData == keep, "R7", "rxData kept", int'(rxData), int'(keep));
    repeat (3) @(posedge sclk);
    @(negedge clk);
    check(lastPer == 6, "R7", "divider kept", lastPer, 6);

    // R7 disable mid-frame with a buffered word
    loopOn = 1'b1;
    sendWord(16'h0F0F);
    sendWord(16'hC001);
    while (!sdoOe) @(negedge clk);
    repeat (20) @(negedge clk);
    portEn = 1'b0;
    repeat (10) @(negedge clk);
    portEn = 1'b1;
    drain();
    check(rxData == 16'hC001, "R7", "buffered word after restart", int'(rxData), 16'hC001);

    finishRun();
  end
endmodule